// File: doc/BRIEF.md
# Double-Buffered Nibble-Loaded DAC Front End

This block is the digital side of a 10-bit voltage-output converter that accepts a 12-bit host word. A host with an 8-bit bus builds the word in a 12-bit staging register. It writes either three separate 4-bit nibbles or one byte followed by one nibble. The address lines pick which nibbles a write fills.

A separate active-low load strobe copies the whole staging word into the output register in a single cycle. The converter code therefore changes all at once, never nibble by nibble. The two lowest word bits are padding below the converter's resolution. The converter code is the upper ten bits. A flag shows when the most recently loaded word carried nonzero padding.

An active-low clear empties both registers. All inputs are sampled on the rising clock edge.

Top module: `dac_frontend`

## Requirements
- R1: After the synchronous active-high reset, `dac_code` is 0 and `pad_flag` is 0.
- R2: A write (`cs_n`=0 and `wr_n`=0 at a clock edge) with `addr`=00 stores `bus[3:0]` into word bits [3:0] and `bus[7:4]` into word bits [7:4].
- R3: A write with `addr`=01 stores `bus[7:4]` into word bits [11:8].
- R4: A write with `addr`=10 stores `bus[7:4]` into word bits [3:0].
- R5: A write with `addr`=11 stores `bus[7:4]` into word bits [7:4].
- R6: The staging word does not change when `cs_n` or `wr_n` is high at an edge. A write leaves the nibbles it does not address unchanged.
- R7: `dac_code` and `pad_flag` change only at an edge where `load_n`=0 or `clr_n`=0. Writes alone never reach the outputs.
- R8: When a write and a load fall on the same edge, the output register takes the staging word as it was before that write.
- R9: `clr_n`=0 at an edge zeroes the staging word, `dac_code` and `pad_flag`. This takes priority over a write and a load at the same edge.
- R10: After a load, `dac_code` equals word bits [11:2]. `pad_flag` is 1 exactly when word bits [1:0] are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Nibble select for a write |
| bus | input | 8 | Write data |
| load_n | input | 1 | Transfer staging word to output register, active low |
| clr_n | input | 1 | Clear both registers, active low |
| dac_code | output | 10 | Code for the converter core |
| pad_flag | output | 1 | Last loaded word had nonzero padding bits |

## Verification
A corrupted staging nibble is invisible at the ports until the next load. At that point it appears in `dac_code` or `pad_flag` one edge after the load. For this reason every write pattern is followed by a load before it is judged.

A wrong output register shows up in the first cycle after the fault. The bench compares both outputs on every cycle against a word model. This includes hold cycles, where any unrequested change is caught immediately.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    SEL_BYTE = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_MID  = 2'b11
  } nib_sel_e;

  localparam int unsigned NIB_LOW  = 0;
  localparam int unsigned NIB_MID  = 1;
  localparam int unsigned NIB_HIGH = 2;
endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode
  import dacfe_pkg::*;
#(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NUM_NIB = 3,
  localparam int unsigned BUS_W  = 2 * NIB_W,
  localparam int unsigned WORD_W = NIB_W * NUM_NIB
) (
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic [1:0]         addr,
  input  logic [BUS_W-1:0]   bus,
  output logic [NUM_NIB-1:0] nib_we,
  output logic [WORD_W-1:0]  nib_d
);
  logic              wr_act;
  logic [NIB_W-1:0]  hi_half;
  logic [NIB_W-1:0]  lo_half;

  assign wr_act  = ~cs_n & ~wr_n;
  assign hi_half = bus[BUS_W-1:NIB_W];
  assign lo_half = bus[NIB_W-1:0];

  always_comb begin
    nib_we = '0;
    for (int i = 0; i < int'(NUM_NIB); i++) begin
      nib_d[i*NIB_W +: NIB_W] = hi_half;
    end
    if (wr_act) begin
      unique case (nib_sel_e'(addr))
        SEL_BYTE: begin
          nib_we[NIB_LOW] = 1'b1;
          nib_we[NIB_MID] = 1'b1;
          nib_d[NIB_LOW*NIB_W +: NIB_W] = lo_half;
        end
        SEL_HIGH: nib_we[NIB_HIGH] = 1'b1;
        SEL_LOW:  nib_we[NIB_LOW]  = 1'b1;
        SEL_MID:  nib_we[NIB_MID]  = 1'b1;
        default:  nib_we = '0;
      endcase
    end
  end
endmodule

// File: rtl/dacfe_inlatch.sv
module dacfe_inlatch #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NUM_NIB = 3,
  localparam int unsigned WORD_W = NIB_W * NUM_NIB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_n,
  input  logic [NUM_NIB-1:0] nib_we,
  input  logic [WORD_W-1:0]  nib_d,
  output logic [WORD_W-1:0]  word
);
  for (genvar g = 0; g < int'(NUM_NIB); g++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst || !clr_n) begin
        word[g*NIB_W +: NIB_W] <= '0;
      end else if (nib_we[g]) begin
        word[g*NIB_W +: NIB_W] <= nib_d[g*NIB_W +: NIB_W];
      end
    end
  end
endmodule

// File: rtl/dacfe_outreg.sv
module dacfe_outreg #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned PAD_W  = 2,
  localparam int unsigned CODE_W = WORD_W - PAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output logic              pad_nz
);
  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      code   <= '0;
      pad_nz <= 1'b0;
    end else if (!load_n) begin
      code   <= word[WORD_W-1:PAD_W];
      pad_nz <= |word[PAD_W-1:0];
    end
  end
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NUM_NIB = 3,
  parameter int unsigned PAD_W   = 2,
  localparam int unsigned BUS_W  = 2 * NIB_W,
  localparam int unsigned WORD_W = NIB_W * NUM_NIB,
  localparam int unsigned CODE_W = WORD_W - PAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  bus,
  input  logic              load_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] dac_code,
  output logic              pad_flag
);
  logic [NUM_NIB-1:0] nib_we;
  logic [WORD_W-1:0]  nib_d;
  logic [WORD_W-1:0]  in_word;

  dacfe_decode #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_decode (
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .bus    (bus),
    .nib_we (nib_we),
    .nib_d  (nib_d)
  );

  dacfe_inlatch #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_inlatch (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .nib_we (nib_we),
    .nib_d  (nib_d),
    .word   (in_word)
  );

  dacfe_outreg #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_outreg (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .load_n (load_n),
    .word   (in_word),
    .code   (dac_code),
    .pad_nz (pad_flag)
  );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned PAD_W  = 2,
  localparam int unsigned CODE_W = WORD_W - PAD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic              load_n,
  input logic              clr_n,
  input logic [WORD_W-1:0] in_word,
  input logic [CODE_W-1:0] dac_code,
  input logic              pad_flag
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && !pad_flag));

  a_r6_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    ((cs_n || wr_n) && clr_n) |=> $stable(in_word));

  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && clr_n) |=> ($stable(dac_code) && $stable(pad_flag)));

  // R8: the load takes the word present at the edge, before any same-edge write
  a_r8_load_old_word: assert property (@(posedge clk) disable iff (rst)
    (!load_n && clr_n) |=> (dac_code == $past(in_word[WORD_W-1:PAD_W])));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (dac_code == '0 && !pad_flag && in_word == '0));

  a_r10_pad_flag: assert property (@(posedge clk) disable iff (rst)
    (!load_n && clr_n) |=> (pad_flag == ($past(in_word[PAD_W-1:0]) != '0)));
endmodule

bind dac_frontend dacfe_checker #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .wr_n     (wr_n),
  .load_n   (load_n),
  .clr_n    (clr_n),
  .in_word  (in_word),
  .dac_code (dac_code),
  .pad_flag (pad_flag)
);

// File: tb/dac_frontend_bench.sv
module dac_frontend_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, wr_n = 1'b1, load_n = 1'b1, clr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] bus = 8'h00;
  logic [9:0] dac_code;
  logic       pad_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [9:0] code;
    logic       flag;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // model state, built from the requirements
  logic [11:0] m_word = '0;
  logic [9:0]  m_code = '0;
  logic        m_flag = 1'b0;

  always #4 clk = ~clk;

  dac_frontend u_dac_frontend (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .bus(bus),
    .load_n(load_n), .clr_n(clr_n), .dac_code(dac_code), .pad_flag(pad_flag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the item due in this cycle
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (dac_code !== e.code || pad_flag !== e.flag) begin
        bad++;
        $display("FAIL %s: code=%h flag=%b expected code=%h flag=%b",
                 e.tag, dac_code, pad_flag, e.code, e.flag);
      end
    end
  end

  task automatic step(input bit r, input bit cs, input bit wr, input logic [1:0] a,
                      input logic [7:0] d, input bit ld, input bit cl, input string tag);
    logic [11:0] nw;
    @(negedge clk);
    rst = r; cs_n = cs; wr_n = wr; addr = a; bus = d; load_n = ld; clr_n = cl;
    if (r || !cl) begin
      m_word = '0; m_code = '0; m_flag = 1'b0;
    end else begin
      nw = m_word;
      if (!cs && !wr) begin
        case (a)
          2'b00: nw[7:0]  = d;
          2'b01: nw[11:8] = d[7:4];
          2'b10: nw[3:0]  = d[7:4];
          default: nw[7:4] = d[7:4];
        endcase
      end
      if (!ld) begin
        m_code = m_word[11:2];
        m_flag = (m_word[1:0] != 2'b00);
      end
      m_word = nw;
    end
    sb.push_back('{at: cyc + 1, code: m_code, flag: m_flag, tag: tag});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(0, 0, 0, a, d, 1, 1, tag);
  endtask

  task automatic ld(input string tag);
    step(0, 1, 1, 2'b00, 8'h00, 0, 1, tag);
  endtask

  initial begin
    repeat (3) step(1, 1, 1, 2'b00, 8'h00, 1, 1, "R1");
    // byte + nibble
    wr(2'b00, 8'hA4, "R2");
    wr(2'b01, 8'h70, "R3");
    ld("R2");           // word 7A4
    wr(2'b10, 8'h30, "R4");
    ld("R4");           // word 7A3
    ld("R10");
    wr(2'b11, 8'h50, "R5");
    ld("R5");           // word 753
    // disabled writes
    step(0, 1, 0, 2'b01, 8'hF0, 1, 1, "R6");
    step(0, 0, 1, 2'b10, 8'hF0, 1, 1, "R6");
    ld("R6");
    // writes without load do not reach outputs
    wr(2'b00, 8'hFF, "R7");
    wr(2'b01, 8'hE0, "R7");
    step(0, 1, 1, 2'b00, 8'h00, 1, 1, "R7");
    // write and load on the same edge
    step(0, 0, 0, 2'b01, 8'h10, 0, 1, "R8");
    ld("R8");
    // clear beats write and load
    step(0, 0, 0, 2'b00, 8'h5A, 0, 0, "R9");
    ld("R9");
    // nibble-by-nibble word 9C6 -> flag set
    wr(2'b01, 8'h90, "R10");
    wr(2'b11, 8'hC0, "R10");
    wr(2'b10, 8'h60, "R10");
    ld("R10");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(0, r[0] & r[1], r[2] & r[3], r[5:4], r[15:8], r[6] | r[7],
           (r[19:16] != 4'h0), "R10");
    end
    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R7: %0d expected items left, expected 0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1: watchdog expired at cycle %0d, expected finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule